// File: doc/BRIEF.md
# GCI Serial Frame Interface

This block terminates one general circuit interface (GCI) style serial link inside a larger chip. The receive side and the transmit side each get a line clock at twice the data rate and a frame sync. The block halves the line clock into a bit clock and counts bit times from the sync pulse. It breaks the 32-bit sub-frame of one device into its B1, B2, monitor, D, C/I, A and E fields, and it sends the matching transmit fields back on an open-drain data line.

Two frame shapes are supported. The plain frame is 32 bit times long (256 kbps at an 8 kHz frame rate). The multiplexed frame is 256 bit times long (2048 kbps), with eight devices each owning one 32-bit slot. A channel-select input chooses the slot that is received and transmitted. On the transmit side, a field enable mask chooses which bits of that slot are driven. The line is released during all other bits.

Top module: `gci_frame_if`

## Requirements
- R1: `bclk_out` is a 1x bit clock made from `rx_dclk`. It is 1 during the first half of each bit time and 0 during the second half. It stays 0 until the first receive sync has been seen after reset.
- R2: A sync level sampled on a rising edge of a section's line clock restarts that section's count. The next rising edge starts bit 0 of the frame. A sync that arrives in the middle of a frame throws away the partial frame.
- R3: Received data is sampled on the second rising line-clock edge of each bit time. Fields arrive MSB first. The packed `rx_fields` word has B1 in [31:24], B2 in [23:16], monitor in [15:8], D in [7:6], C/I in [5:2], A in [1] and E in [0].
- R4: After the last bit of a complete frame, `rx_valid` pulses high for exactly one `clk` cycle, with `rx_fields` holding the selected channel. No pulse is given before the first sync.
- R5: `mux_mode`=1 selects a 256-bit frame in which channel c uses bit times 32c to 32c+31, and `ch_sel` picks c. `mux_mode`=0 selects a 32-bit frame, and `ch_sel` is ignored.
- R6: Within the selected channel, `tx_oe`=1 and `tx_data` carries the enabled field bit, MSB first, from the first rising edge of that bit time. During every other bit, and before the first transmit sync, `tx_oe`=0 and `tx_data`=1. The pad pulls low only when both `tx_oe`=1 and `tx_data`=0.
- R7: Bit positions in `tx_field_en` are [6]=B1, [5]=B2, [4]=monitor, [3]=D, [2]=C/I, [1]=A and [0]=E. The `tx_fields` word uses the same layout as `rx_fields`.
- R8: The transmit word, the enable mask, the channel and the mode are captured at the transmit sync. Changes to them later in the frame do not affect that frame.
- R9: While `rst_n` is low, `rx_valid`=0, `tx_oe`=0, `tx_data`=1 and `bclk_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all link lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1 = 256-bit multiplexed frame, 0 = 32-bit frame |
| ch_sel | input | 3 | Channel slot used in multiplexed mode |
| rx_dclk | input | 1 | Receive line clock, twice the bit rate |
| rx_fsync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Receive serial data |
| bclk_out | output | 1 | 1x bit clock made from the receive line clock |
| rx_valid | output | 1 | One-cycle pulse when a frame is complete |
| rx_fields | output | 32 | Packed received fields of the selected channel |
| tx_dclk | input | 1 | Transmit line clock, twice the bit rate |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_fields | input | 32 | Packed fields to transmit |
| tx_field_en | input | 7 | Per-field transmit enable |
| tx_oe | output | 1 | Transmit drive enable (0 = released) |
| tx_data | output | 1 | Transmit bit value, 1 when released |

## Verification
A wrong bit counter or a wrong half-bit phase shows up first on `bclk_out`, at the next bit time. It shows up on `tx_oe` within one bit time, because the drive window moves out of line with the field boundaries. A bad receive shift or a bad channel match stays hidden until the end of the frame, when the `rx_valid` pulse shows wrong fields or arrives at the wrong time. A lost capture at the sync shows in the first transmitted bit of the next frame.

// File: rtl/gci_pkg.sv
package gci_pkg;

   localparam int unsigned SLOT_BITS = 32;
   localparam int unsigned FIELD_NUM = 7;

   // Sub-frame layout, first transmitted bit at [31]
   typedef struct packed {
      logic [7:0] b1;
      logic [7:0] b2;
      logic [7:0] mon;
      logic [1:0] d;
      logic [3:0] ci;
      logic       a;
      logic       e;
   } gci_fields_t;

   // Map a bit offset inside a slot to its enable-mask index (6 = B1 ... 0 = E)
   function automatic logic [2:0] field_index(input logic [4:0] off);
      logic [2:0] idx;
      if (off < 5'd8)        idx = 3'd6;
      else if (off < 5'd16)  idx = 3'd5;
      else if (off < 5'd24)  idx = 3'd4;
      else if (off < 5'd26)  idx = 3'd3;
      else if (off < 5'd30)  idx = 3'd2;
      else if (off == 5'd30) idx = 3'd1;
      else                   idx = 3'd0;
      return idx;
   endfunction

endpackage

// File: rtl/gci_bit_timer.sv
module gci_bit_timer
   import gci_pkg::*;
#(
   parameter int unsigned NUM_DEV = 8,
   parameter int unsigned CNT_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dclk,
   input  logic             fsync,
   input  logic             mux_req,
   output logic             mux_act,
   output logic             locked,
   output logic             half,
   output logic             bit_start,
   output logic             bit_mid,
   output logic             sync_evt,
   output logic [CNT_W-1:0] bit_idx
);

   localparam logic [CNT_W-1:0] LAST_MUX = CNT_W'(NUM_DEV * SLOT_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_NRM = CNT_W'(SLOT_BITS - 1);

   logic             dclk_q;
   logic             rise;
   logic [CNT_W-1:0] last_idx;

   assign rise     = dclk & ~dclk_q;
   assign last_idx = mux_act ? LAST_MUX : LAST_NRM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk_q    <= 1'b0;
         mux_act   <= 1'b0;
         locked    <= 1'b0;
         half      <= 1'b1;
         bit_start <= 1'b0;
         bit_mid   <= 1'b0;
         sync_evt  <= 1'b0;
         bit_idx   <= '0;
      end else begin
         dclk_q    <= dclk;
         bit_start <= 1'b0;
         bit_mid   <= 1'b0;
         sync_evt  <= 1'b0;
         if (rise) begin
            if (fsync) begin
               // park on the last bit so the next edge opens bit 0
               locked   <= 1'b1;
               half     <= 1'b1;
               sync_evt <= 1'b1;
               mux_act  <= (NUM_DEV > 1) && mux_req;
               bit_idx  <= ((NUM_DEV > 1) && mux_req) ? LAST_MUX : LAST_NRM;
            end else if (locked) begin
               half <= ~half;
               if (half) begin
                  bit_idx   <= (bit_idx == last_idx) ? '0 : bit_idx + 1'b1;
                  bit_start <= 1'b1;
               end else begin
                  bit_mid <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/gci_rx_deframe.sv
module gci_rx_deframe
   import gci_pkg::*;
#(
   parameter int unsigned NUM_DEV = 8,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned CH_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_mid,
   input  logic             sync_evt,
   input  logic             mux_act,
   input  logic [CNT_W-1:0] bit_idx,
   input  logic             rx_data,
   input  logic [CH_W-1:0]  ch_sel,
   output logic             rx_valid,
   output gci_fields_t      rx_fields
);

   localparam logic [CNT_W-1:0] LAST_MUX = CNT_W'(NUM_DEV * SLOT_BITS - 1);
   localparam logic [CNT_W-1:0] LAST_NRM = CNT_W'(SLOT_BITS - 1);

   logic [CH_W-1:0]      ch_q;
   logic                 hit;
   logic [SLOT_BITS-1:0] shreg;
   logic [SLOT_BITS-1:0] shnext;
   logic                 last_bit;

   generate
      if (NUM_DEV == 1) begin : g_single
         assign hit = 1'b1;
      end else begin : g_multi
         assign hit = !mux_act || (bit_idx[CNT_W-1:5] == ch_q);
      end
   endgenerate

   assign last_bit = bit_idx == (mux_act ? LAST_MUX : LAST_NRM);
   assign shnext   = hit ? {shreg[SLOT_BITS-2:0], rx_data} : shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_q      <= '0;
         shreg     <= '0;
         rx_valid  <= 1'b0;
         rx_fields <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (sync_evt) ch_q <= ch_sel;
         if (bit_mid) begin
            shreg <= shnext;
            if (last_bit) begin
               rx_valid  <= 1'b1;
               rx_fields <= gci_fields_t'(shnext);
            end
         end
      end
   end

endmodule

// File: rtl/gci_tx_frame.sv
module gci_tx_frame
   import gci_pkg::*;
#(
   parameter int unsigned NUM_DEV = 8,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned CH_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_start,
   input  logic                 sync_evt,
   input  logic                 mux_act,
   input  logic [CNT_W-1:0]     bit_idx,
   input  logic [CH_W-1:0]      ch_sel,
   input  gci_fields_t          tx_fields,
   input  logic [FIELD_NUM-1:0] tx_field_en,
   output logic                 tx_oe,
   output logic                 tx_data
);

   logic [SLOT_BITS-1:0] word_q;
   logic [FIELD_NUM-1:0] en_q;
   logic [CH_W-1:0]      ch_q;
   logic [4:0]           off;
   logic                 hit;
   logic                 drive;

   assign off = bit_idx[4:0];

   generate
      if (NUM_DEV == 1) begin : g_single
         assign hit = 1'b1;
      end else begin : g_multi
         assign hit = !mux_act || (bit_idx[CNT_W-1:5] == ch_q);
      end
   endgenerate

   assign drive = hit && en_q[field_index(off)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         en_q    <= '0;
         ch_q    <= '0;
         tx_oe   <= 1'b0;
         tx_data <= 1'b1;
      end else if (sync_evt) begin
         word_q  <= tx_fields;
         en_q    <= tx_field_en;
         ch_q    <= ch_sel;
         tx_oe   <= 1'b0;
         tx_data <= 1'b1;
      end else if (bit_start) begin
         tx_oe   <= drive;
         tx_data <= drive ? word_q[~off] : 1'b1;
      end
   end

endmodule

// File: rtl/gci_frame_if.sv
module gci_frame_if
   import gci_pkg::*;
#(
   parameter  int unsigned NUM_DEV = 8,
   localparam int unsigned CH_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int unsigned CNT_W   = $clog2(NUM_DEV * SLOT_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mux_mode,
   input  logic [CH_W-1:0]      ch_sel,
   input  logic                 rx_dclk,
   input  logic                 rx_fsync,
   input  logic                 rx_data,
   output logic                 bclk_out,
   output logic                 rx_valid,
   output logic [SLOT_BITS-1:0] rx_fields,
   input  logic                 tx_dclk,
   input  logic                 tx_fsync,
   input  logic [SLOT_BITS-1:0] tx_fields,
   input  logic [FIELD_NUM-1:0] tx_field_en,
   output logic                 tx_oe,
   output logic                 tx_data
);

   if (NUM_DEV == 0 || NUM_DEV > 8 || (NUM_DEV & (NUM_DEV - 1)) != 0) begin : g_bad_num_dev
      $error("gci_frame_if: NUM_DEV must be 1, 2, 4 or 8");
   end

   logic             rx_mux, rx_locked, rx_half, rx_start, rx_mid, rx_sync_evt;
   logic             tx_mux, tx_locked, tx_half, tx_start, tx_mid, tx_sync_evt;
   logic [CNT_W-1:0] rx_idx, tx_idx;
   gci_fields_t      rx_word;

   gci_bit_timer #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) u_rx_tmr (
      .clk(clk), .rst_n(rst_n), .dclk(rx_dclk), .fsync(rx_fsync),
      .mux_req(mux_mode), .mux_act(rx_mux), .locked(rx_locked),
      .half(rx_half), .bit_start(rx_start), .bit_mid(rx_mid),
      .sync_evt(rx_sync_evt), .bit_idx(rx_idx)
   );

   gci_bit_timer #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) u_tx_tmr (
      .clk(clk), .rst_n(rst_n), .dclk(tx_dclk), .fsync(tx_fsync),
      .mux_req(mux_mode), .mux_act(tx_mux), .locked(tx_locked),
      .half(tx_half), .bit_start(tx_start), .bit_mid(tx_mid),
      .sync_evt(tx_sync_evt), .bit_idx(tx_idx)
   );

   gci_rx_deframe #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W), .CH_W(CH_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_mid(rx_mid), .sync_evt(rx_sync_evt),
      .mux_act(rx_mux), .bit_idx(rx_idx), .rx_data(rx_data),
      .ch_sel(ch_sel), .rx_valid(rx_valid), .rx_fields(rx_word)
   );

   gci_tx_frame #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W), .CH_W(CH_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .bit_start(tx_start), .sync_evt(tx_sync_evt),
      .mux_act(tx_mux), .bit_idx(tx_idx), .ch_sel(ch_sel),
      .tx_fields(gci_fields_t'(tx_fields)), .tx_field_en(tx_field_en),
      .tx_oe(tx_oe), .tx_data(tx_data)
   );

   assign rx_fields = rx_word;
   assign bclk_out  = rx_locked & ~rx_half;

   logic unused_ok;
   assign unused_ok = &{1'b0, rx_start, tx_mid, tx_half};

endmodule

// File: rtl/gci_frame_chk.sv
module gci_frame_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic rx_mid,
   input logic rx_locked,
   input logic bclk_out,
   input logic tx_oe,
   input logic tx_data,
   input logic tx_locked,
   input logic tx_start,
   input logic tx_sync_evt
);

   // R4
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R4
   rx_at_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($past(rx_mid) && rx_locked));

   // R6
   tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> tx_data);

   // R6
   tx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_oe |-> tx_locked);

   // R6
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_start || tx_sync_evt) |=> ($stable(tx_oe) && $stable(tx_data)));

   // R1
   bclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_locked |-> !bclk_out);

endmodule

bind gci_frame_if gci_frame_chk u_chk (.*);

// File: tb/sim_gci_frame_if.sv
module sim_gci_frame_if;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mux_mode = 1'b0;
   logic [2:0]  ch_sel = '0;
   logic        rx_dclk = 1'b0, rx_fsync = 1'b0, rx_data = 1'b0;
   logic        tx_dclk = 1'b0, tx_fsync = 1'b0;
   logic [31:0] tx_fields = '0;
   logic [6:0]  tx_field_en = '0;
   logic        bclk_out, rx_valid, tx_oe, tx_data;
   logic [31:0] rx_fields;

   always #2 clk = ~clk;

   gci_frame_if u0 (
      .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .ch_sel(ch_sel),
      .rx_dclk(rx_dclk), .rx_fsync(rx_fsync), .rx_data(rx_data),
      .bclk_out(bclk_out), .rx_valid(rx_valid), .rx_fields(rx_fields),
      .tx_dclk(tx_dclk), .tx_fsync(tx_fsync), .tx_fields(tx_fields),
      .tx_field_en(tx_field_en), .tx_oe(tx_oe), .tx_data(tx_data)
   );

   int unsigned n_run = 0, n_fail = 0, vcnt = 0;
   logic [31:0] vcap;
   logic        finished = 1'b0;

   logic [255:0] rxv;
   logic [255:0] got_oe, got_d, got_bs, got_bm;
   logic [31:0]  x_word;
   logic [6:0]   x_en;
   logic [2:0]   x_ch;
   logic         x_mux;

   always @(negedge clk) if (rx_valid) begin vcnt++; vcap = rx_fields; end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic pbit(input int i, input int seed);
      logic [31:0] v = 32'(i) * 32'h9E37_79B9 ^ 32'(seed);
      return ^v[31:11];
   endfunction

   task automatic fill(input int seed);
      for (int i = 0; i < 256; i++) rxv[i] = pbit(i, seed);
   endtask

   // one line clock period: 2 clk high, 2 clk low; sample while high
   task automatic tick(input logic s, output logic o_oe, output logic o_d, output logic o_bc);
      @(negedge clk);
      rx_dclk = 1'b1; tx_dclk = 1'b1; rx_fsync = s; tx_fsync = s;
      @(negedge clk);
      @(negedge clk);
      o_oe = tx_oe; o_d = tx_data; o_bc = bclk_out;
      rx_fsync = 1'b0; tx_fsync = 1'b0; rx_dclk = 1'b0; tx_dclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_frame(input logic mux, input logic [2:0] ch, input int nbits, input int chg_at);
      logic o1, o2, o3;
      mux_mode = mux; ch_sel = ch;
      x_word = tx_fields; x_en = tx_field_en; x_ch = ch; x_mux = mux;
      tick(1'b1, o1, o2, o3);
      for (int i = 0; i < nbits; i++) begin
         rx_data = rxv[i];
         if (i == chg_at) begin
            tx_fields = ~tx_fields; tx_field_en = ~tx_field_en;
            ch_sel = ch + 3'd1; mux_mode = ~mux;
         end
         tick(1'b0, got_oe[i], got_d[i], got_bs[i]);
         tick(1'b0, o1, o2, got_bm[i]);
      end
   endtask

   function automatic logic [31:0] exp_rx(input int c);
      logic [31:0] w;
      for (int k = 0; k < 32; k++) w[31-k] = rxv[c*32+k];
      return w;
   endfunction

   task automatic chk_tx(input string req, input int nbits);
      int bad = 0;
      for (int i = 0; i < nbits; i++) begin
         int k = i % 32;
         int fi = (k < 8) ? 6 : (k < 16) ? 5 : (k < 24) ? 4 : (k < 26) ? 3 : (k < 30) ? 2 : (k == 30) ? 1 : 0;
         logic hit = !x_mux || (i / 32 == int'(x_ch));
         logic eo = hit && x_en[fi];
         logic ed = eo ? x_word[31-k] : 1'b1;
         if (got_oe[i] !== eo || got_d[i] !== ed) bad++;
      end
      chk(req, 32'(bad), 32'd0);
   endtask

   task automatic chk_bclk(input string req, input int nbits);
      int bad = 0;
      for (int i = 0; i < nbits; i++) if (got_bs[i] !== 1'b1 || got_bm[i] !== 1'b0) bad++;
      chk(req, 32'(bad), 32'd0);
   endtask

   task automatic t_reset;
      chk("R9 rx_valid", 32'(rx_valid), 32'd0);
      chk("R9 tx_oe", 32'(tx_oe), 32'd0);
      chk("R9 tx_data", 32'(tx_data), 32'd1);
      chk("R9 bclk_out", 32'(bclk_out), 32'd0);
   endtask

   task automatic t_idle;
      int oe_seen = 0, bc_seen = 0;
      int v0 = vcnt;
      logic a, b, c;
      for (int i = 0; i < 80; i++) begin
         tick(1'b0, a, b, c);
         if (a) oe_seen++;
         if (c) bc_seen++;
      end
      chk("R4 no pulse before sync", 32'(vcnt - v0), 32'd0);
      chk("R6 released before sync", 32'(oe_seen), 32'd0);
      chk("R1 bclk idle before sync", 32'(bc_seen), 32'd0);
   endtask

   task automatic t_normal;
      int v0 = vcnt;
      fill(11);
      tx_fields = 32'h5A3C_E196; tx_field_en = 7'h7F;
      run_frame(1'b0, 3'd3, 32, -1);
      chk("R4 one pulse per frame", 32'(vcnt - v0), 32'd1);
      chk("R3 R5 normal fields, ch_sel ignored", vcap, exp_rx(0));
      chk_tx("R6 normal full transmit", 32);
      chk_bclk("R1 bit clock halves", 32);
   endtask

   task automatic t_mask;
      int v0 = vcnt;
      fill(23);
      tx_fields = 32'hC3A5_0F96; tx_field_en = 7'b0011000;
      run_frame(1'b0, 3'd0, 32, -1);
      chk("R3 fields second frame", vcap, exp_rx(0));
      chk("R4 pulse count", 32'(vcnt - v0), 32'd1);
      chk_tx("R7 D and CI only", 32);
      tx_field_en = 7'b1000011;
      run_frame(1'b0, 3'd0, 32, -1);
      chk_tx("R7 B1, A and E only", 32);
   endtask

   task automatic t_mux(input logic [2:0] ch, input int seed);
      int v0 = vcnt;
      fill(seed);
      tx_fields = 32'h0123_4567 ^ {29'd0, ch}; tx_field_en = 7'h7F;
      run_frame(1'b1, ch, 256, -1);
      chk("R4 R5 mux pulse count", 32'(vcnt - v0), 32'd1);
      chk("R5 mux channel fields", vcap, exp_rx(int'(ch)));
      chk_tx("R5 R6 mux slot transmit", 256);
   endtask

   task automatic t_latch;
      fill(41);
      tx_fields = 32'h9ABC_DEF0; tx_field_en = 7'h7F;
      run_frame(1'b0, 3'd2, 32, 5);
      chk_tx("R8 fields captured at sync", 32);
      mux_mode = 1'b0;
   endtask

   task automatic t_resync;
      int v0;
      fill(57);
      run_frame(1'b0, 3'd0, 12, -1);
      v0 = vcnt;
      fill(73);
      tx_fields = 32'h7E81_3CC3; tx_field_en = 7'h7F;
      run_frame(1'b0, 3'd0, 32, -1);
      chk("R2 resync single pulse", 32'(vcnt - v0), 32'd1);
      chk("R2 resync fields", vcap, exp_rx(0));
      chk_tx("R2 resync transmit aligned", 32);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_idle();
      t_normal();
      t_mask();
      t_mux(3'd5, 91);
      t_mux(3'd7, 97);
      t_mux(3'd0, 99);
      t_latch();
      t_resync();
      repeat (8) @(negedge clk);
      finish_run();
   end

endmodule